// File: doc/BRIEF.md
# Analog Column Clock Enable Generator

This block produces one clock-enable strobe per analog column, all in the domain of a single fast system clock. Each column picks its source from four candidates through a 2-bit code: two global timing strobes and two auxiliary strobes. Each auxiliary strobe is itself taken from one line of a bank of digital-block outputs, chosen by a select field that all columns share. A per-column override bit replaces the chosen source with the system clock itself, so every cycle counts as a source edge. A per-column divide field then passes through one source edge in every 1, 2, 4 or 8.

The result is a single-cycle enable, `col_en`, that downstream column logic and synchronizers qualify their work with. No data flows through this block: all pins are plain control and strobe lines, so there is no valid/ready handshake and no back-pressure. Any change to a column's configuration restarts that column's divider, so a partial period never turns into a pulse.

Top module: `colclk_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `col_en` is 0, and after reset each divider starts counting from zero.
- R2: The column source code selects 00 = `glb_stb[0]`, 01 = `glb_stb[1]`, 10 = auxiliary strobe A, 11 = auxiliary strobe B.
- R3: Auxiliary strobe A is `dig_out[auxa_sel]` and auxiliary strobe B is `dig_out[auxb_sel]`, shared by all columns.
- R4: When a column's override bit is 1, every cycle is a source edge regardless of its source code. With divide code 00 the enable stays high in every cycle after the configuration settles.
- R5: The divide code selects 00 = every edge, 01 = every 2nd, 10 = every 4th, 11 = every 8th source edge. The first pulse comes on the Nth edge after reset or after a configuration change.
- R6: Without override, only rising edges count: a source held high for many cycles counts as a single edge.
- R7: The enable pulse for a counted edge appears in the cycle after the sampling clock edge at which the source was first seen high.
- R8: A cycle in which a column's source code, override bit or divide code differs from the previous cycle, or either auxiliary select changes, produces no pulse on that column and restarts its divider at zero.
- R9: Without the override-and-no-divide combination, `col_en` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_stb | input | 2 | The two global timing strobes |
| dig_out | input | NDIG | Digital-block output lines feeding the auxiliary strobes |
| auxa_sel | input | SELW | Line index for auxiliary strobe A |
| auxb_sel | input | SELW | Line index for auxiliary strobe B |
| col_src | input | 2*NCOL | 2-bit source code per column, column c at bits [2c+1:2c] |
| col_sysovr | input | NCOL | System-clock override bit per column |
| col_div | input | 2*NCOL | 2-bit divide code per column, column c at bits [2c+1:2c] |
| col_en | output | NCOL | Single-cycle enable per column |

## Verification
The hardest situation to reach from the ports is a configuration change in the middle of a divide period, where a partly filled count must be discarded rather than completed. The stimulus runs a column at divide-by-8 on a fast strobe, alters the divide code a few edges in, then moves an auxiliary select while that column is not even using it, so both the direct and the shared restart paths are hit mid-count. A reference model in the bench tracks edges and counts from the requirements and predicts every cycle of `col_en`, which also covers held-high sources and the override mode.

// File: rtl/colclk_pkg.sv
package colclk_pkg;

  typedef enum logic [1:0] {
    SRC_GLB0 = 2'b00,
    SRC_GLB1 = 2'b01,
    SRC_AUXA = 2'b10,
    SRC_AUXB = 2'b11
  } src_e;

  localparam int unsigned CNTW = 3;

  // Terminal count for a divide code: 1 << code, minus one.
  function automatic logic [CNTW-1:0] div_last(input logic [1:0] code);
    logic [CNTW:0] full;
    full = (CNTW+1)'(1) << code;
    return CNTW'(full - 1'b1);
  endfunction

endpackage

// File: rtl/colclk_auxpick.sv
module colclk_auxpick #(
  parameter int unsigned NDIG = 8,
  parameter int unsigned SELW = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic [NDIG-1:0] dig_out,
  input  logic [SELW-1:0] sel,
  output logic            pick
);
  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      if (sel == SELW'(i)) pick = dig_out[i];
    end
  end
endmodule

// File: rtl/colclk_srcsel.sv
module colclk_srcsel
  import colclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] glb_stb,
  input  logic [1:0] aux_stb,
  input  logic [1:0] src,
  input  logic       sysovr,
  output logic       tick
);
  logic sel_lvl;
  logic sel_prev;

  always_comb begin
    unique case (src_e'(src))
      SRC_GLB0: sel_lvl = glb_stb[0];
      SRC_GLB1: sel_lvl = glb_stb[1];
      SRC_AUXA: sel_lvl = aux_stb[0];
      SRC_AUXB: sel_lvl = aux_stb[1];
      default:  sel_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_lvl;
  end

  assign tick = sysovr | (sel_lvl & ~sel_prev);
endmodule

// File: rtl/colclk_div.sv
module colclk_div
  import colclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] div,
  output logic       en
);
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] last;

  assign last = div_last(div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      en  <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      en  <= 1'b0;
    end else if (tick) begin
      if (cnt == last) begin
        cnt <= '0;
        en  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        en  <= 1'b0;
      end
    end else begin
      en <= 1'b0;
    end
  end
endmodule

// File: rtl/colclk_gen.sv
module colclk_gen
  import colclk_pkg::*;
#(
  parameter int unsigned NCOL = 2,
  parameter int unsigned NDIG = 8,
  parameter int unsigned SELW = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        glb_stb,
  input  logic [NDIG-1:0]   dig_out,
  input  logic [SELW-1:0]   auxa_sel,
  input  logic [SELW-1:0]   auxb_sel,
  input  logic [2*NCOL-1:0] col_src,
  input  logic [NCOL-1:0]   col_sysovr,
  input  logic [2*NCOL-1:0] col_div,
  output logic [NCOL-1:0]   col_en
);
  localparam int unsigned CFGW = 5;
  localparam int unsigned AUXW = 2 * SELW;

  logic [1:0]      aux_stb;
  logic [AUXW-1:0] aux_now, aux_q;
  logic            aux_chg;

  colclk_auxpick #(.NDIG(NDIG), .SELW(SELW)) u_pick_a (
    .dig_out(dig_out), .sel(auxa_sel), .pick(aux_stb[0]));
  colclk_auxpick #(.NDIG(NDIG), .SELW(SELW)) u_pick_b (
    .dig_out(dig_out), .sel(auxb_sel), .pick(aux_stb[1]));

  assign aux_now = {auxb_sel, auxa_sel};

  // Configuration history, loaded every cycle including reset.
  always_ff @(posedge clk) aux_q <= aux_now;
  assign aux_chg = (aux_now != aux_q);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [CFGW-1:0] cfg_now, cfg_q;
    logic            restart;
    logic            tick;

    assign cfg_now = {col_src[2*c +: 2], col_sysovr[c], col_div[2*c +: 2]};

    always_ff @(posedge clk) cfg_q <= cfg_now;
    assign restart = aux_chg | (cfg_now != cfg_q);

    colclk_srcsel u_src (
      .clk(clk), .rst_n(rst_n), .glb_stb(glb_stb), .aux_stb(aux_stb),
      .src(col_src[2*c +: 2]), .sysovr(col_sysovr[c]), .tick(tick));

    colclk_div u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .div(col_div[2*c +: 2]), .en(col_en[c]));
  end
endmodule

// File: rtl/colclk_chk.sv
module colclk_chk #(
  parameter int unsigned NCOL = 2,
  parameter int unsigned SELW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SELW-1:0]   auxa_sel,
  input logic [SELW-1:0]   auxb_sel,
  input logic [2*NCOL-1:0] col_src,
  input logic [NCOL-1:0]   col_sysovr,
  input logic [2*NCOL-1:0] col_div,
  input logic [NCOL-1:0]   col_en
);
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (col_en == '0);
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_chk
    logic [4:0] cfg;
    assign cfg = {col_src[2*c +: 2], col_sysovr[c], col_div[2*c +: 2]};

    a_r8_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg != $past(cfg) || auxa_sel != $past(auxa_sel) || auxb_sel != $past(auxb_sel))
      |=> !col_en[c]);

    a_r4_override_solid: assert property (@(posedge clk) disable iff (!rst_n)
      (col_sysovr[c] && col_div[2*c +: 2] == 2'b00 && $stable(cfg)
        && $stable(auxa_sel) && $stable(auxb_sel))
      |=> col_en[c]);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (col_en[c] && !(col_sysovr[c] && col_div[2*c +: 2] == 2'b00))
      |=> !col_en[c]);
  end
endmodule

bind colclk_gen colclk_chk #(.NCOL(NCOL), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .auxa_sel(auxa_sel), .auxb_sel(auxb_sel),
  .col_src(col_src), .col_sysovr(col_sysovr), .col_div(col_div),
  .col_en(col_en));

// File: tb/colclk_gen_bench.sv
module colclk_gen_bench;
  localparam int NCOL = 2;
  localparam int NDIG = 8;
  localparam int SELW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        glb_stb = '0;
  logic [NDIG-1:0]   dig_out = '0;
  logic [SELW-1:0]   auxa_sel = '0;
  logic [SELW-1:0]   auxb_sel = '0;
  logic [2*NCOL-1:0] col_src = '0;
  logic [NCOL-1:0]   col_sysovr = '0;
  logic [2*NCOL-1:0] col_div = '0;
  logic [NCOL-1:0]   col_en;

  colclk_gen #(.NCOL(NCOL), .NDIG(NDIG), .SELW(SELW)) u_colclk_gen (.*);

  always #2 clk = ~clk;

  int    n_run = 0, n_fail = 0, cyc = 0;
  int    p0 = 4, p1 = 3;
  bit    hold_hi = 0;
  bit    done = 0;
  string tag = "R1";

  // Source pattern generator, driven away from the active edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    glb_stb[0] <= hold_hi | (cyc % p0 == 0);
    glb_stb[1] <= hold_hi | (cyc % p1 == 0);
    for (int i = 0; i < NDIG; i++) dig_out[i] <= hold_hi | (cyc % (i + 2) == 0);
  end

  // Reference model from the requirements; pushes expected enables.
  logic [NCOL-1:0] expq[$];
  int        m_cnt [NCOL];
  bit        m_prev[NCOL];
  bit [4:0]  m_cfg [NCOL];
  bit [5:0]  m_aux;
  always @(posedge clk) begin
    logic [NCOL-1:0] e;
    bit auxchg;
    e = '0;
    auxchg = ({auxb_sel, auxa_sel} != m_aux);
    for (int c = 0; c < NCOL; c++) begin
      bit [1:0] s; bit lvl, edg, chg; bit [4:0] cf; int last;
      s = col_src[2*c +: 2];
      lvl = (s == 2'b00) ? glb_stb[0] : (s == 2'b01) ? glb_stb[1] :
            (s == 2'b10) ? dig_out[auxa_sel] : dig_out[auxb_sel];
      cf = {s, col_sysovr[c], col_div[2*c +: 2]};
      chg = auxchg || (cf != m_cfg[c]);
      edg = col_sysovr[c] || (lvl && !m_prev[c]);
      last = (1 << col_div[2*c +: 2]) - 1;
      if (!rst_n) begin
        m_cnt[c] = 0; lvl = 0;
      end else if (chg) begin
        m_cnt[c] = 0;
      end else if (edg) begin
        if (m_cnt[c] == last) begin m_cnt[c] = 0; e[c] = 1'b1; end
        else m_cnt[c] = m_cnt[c] + 1;
      end
      m_prev[c] = lvl;
      m_cfg[c] = cf;
    end
    m_aux = {auxb_sel, auxa_sel};
    expq.push_back(e);
  end

  // Monitor: compares each cycle's enable with the expected entry.
  always @(negedge clk) begin
    if (expq.size() > 0 && !done) begin
      logic [NCOL-1:0] x;
      x = expq.pop_front();
      n_run++;
      if (col_en !== x) begin
        n_fail++;
        $display("FAIL %s cycle %0d: col_en=%b expected=%b", tag, cyc, col_en, x);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    n_run++;  // R1: outputs idle during reset
    if (col_en !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: col_en=%b expected=00", col_en);
    end
    rst_n = 1'b1;
    tag = "R2,R7";
    col_src = {2'b01, 2'b00}; col_div = '0;
    run(40);
    tag = "R3";
    auxa_sel = 3'd5; auxb_sel = 3'd2;
    col_src = {2'b11, 2'b10};
    run(40);
    tag = "R5,R9";
    col_src = {2'b01, 2'b00}; col_div = {2'b11, 2'b01};
    run(60);
    col_div = {2'b01, 2'b10};
    run(60);
    tag = "R6";
    col_src = {2'b10, 2'b00}; col_div = '0;
    run(3); hold_hi = 1; run(20); hold_hi = 0; run(10);
    tag = "R4";
    col_sysovr = 2'b11; col_div = {2'b11, 2'b00};
    run(30);
    col_src = {2'b00, 2'b11};
    run(20);
    tag = "R8";
    col_sysovr = '0; p0 = 2;
    col_src = {2'b01, 2'b00}; col_div = {2'b00, 2'b11};
    run(7);
    col_div = {2'b00, 2'b10};
    run(5);
    auxa_sel = 3'd1;
    run(30);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule